// File: doc/BRIEF.md
# Master/Slave Serial Peripheral Port

A full-duplex SPI port for an 8-bit microcontroller. It can run as bus master or as bus slave, and it moves data through a single 8-bit shift register. In master mode the port makes the serial clock from the system clock. In slave mode it follows a serial clock from outside, and it only shifts while its active-low select input is held low. The port uses SPI mode 0: the clock idles low, the receiver samples on the rising edge and the transmitter shifts on the falling edge. A control bit picks whether each byte goes out MSB first or LSB first.

Software uses three registers on a simple CPU bus:

- Control register (address 0).
- Status register (address 1).
- Data register (address 2).

A received byte moves into its own read buffer, so the next byte can shift in while software reads the last one. The port has a transfer-done flag, which can drive an interrupt, and a write-collision flag. In enhanced mode a one-byte transmit buffer lets software queue the next byte while the current one is still shifting.

Top module: `spi_port`

## Requirements
- R1: Pin directions follow the master bit (ctrl[4]) and the enable bit (ctrl[5]).
  - Enabled master: `sck_oe` = 1, `mosi_oe` = 1, `miso_oe` = 0.
  - Enabled slave: `sck_oe` = 0, `mosi_oe` = 0, and `miso_oe` = 1 only while `ss_n` is low.
- R2: In master mode the `ss_n` input has no effect. Transfers give the same data and timing whatever `ss_n` does.
- R3: In slave mode, while `ss_n` is high the port ignores SCK edges.
  - It sets no flag.
  - Its bit counter returns to zero, so a byte that was cut short leaves no trace on the next selected transfer.
- R4: The master SCK period is set by ctrl[1:0] = 0, 1, 2, 3.
  - Normal: 4, 16, 64 or 128 system clocks.
  - With the clock-doubling bit ctrl[2] set: half of each, i.e. 2, 8, 32 or 64.
- R5: ctrl[3] = 1 shifts the byte out and in LSB first. ctrl[3] = 0 shifts it MSB first.
- R6: The transfer is full duplex in mode 0.
  - The master drives MOSI and samples MISO on rising SCK.
  - The slave drives MISO and samples MOSI.
  - The byte received in one transfer is the byte read from the data register afterwards.
- R7: The done flag (status bit 7) is set at the 8th falling SCK edge. For a master this is 8·P clock edges after the edge that accepts the data write, where P is the SCK period. The `irq` output equals the done flag ANDed with the interrupt-enable bit ctrl[6].
- R8: The data-register read value stays at the last completed byte until the next byte completes, even while a new byte is shifting.
- R9: Normal mode (ctrl[7] = 0), writing data while a transfer is busy:
  - The write is discarded.
  - The write-collision flag (status bit 6) is set.
  - The byte being sent is not changed.
- R10: Enhanced mode (ctrl[7] = 1), transmit buffer:
  - A data write fills a one-byte buffer, which loads into the idle shifter on the next clock edge.
  - Status bit 0 reads 1 when the buffer is empty.
  - A write while the buffer is full sets the write-collision flag and is discarded.
- R11: Clearing the flags:
  - A status read followed by a data-register access (read or write) clears both flags.
  - When a flag is set in the same cycle as that clearing access, the setting wins.
- R12: Register map: address 0 = control (reads back), 1 = status, 2 = data. After reset, control reads 0x00 and status reads 0x01. Status bit 1 shows a transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | MISO output enable |
| miso_i | input | 1 | Master data in |
| ss_n | input | 1 | Active-low slave select |

## Verification
The risky coincidence is the end of a transfer landing in the same cycle as the data-register access that clears the flags. In that cycle the port must keep the new done flag, not lose it. The bench starts a fastest-rate master transfer and reads status to arm the clear. It then sweeps the data-register read across the cycles before, at and after the 8th falling edge. For each offset it checks that the flag survives exactly when the read lands on or before the completion edge. A second coincidence is also driven: in enhanced mode, a data write arrives in the same cycle that the buffered byte moves into the shifter, and that write must be accepted without a collision.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  input  logic       ss_n
);
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);
  localparam int DW = 6;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [7:0] ctrl, sh, rxbuf, txbuf, nxt;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] dcnt, half;
  logic [2:0] sck_s;
  logic [1:0] ss_s, mosi_s;
  logic lat, run, sck_q, spif, wcol, armed, txfull;
  logic dbl, lsbf, mstr, en, ie, enh;
  logic busy, sel_s, tick, rise, fall, last, out_bit;
  logic dwr, drd, srd, cwr, load, direct, wset, clr;

  assign dbl  = ctrl[2];
  assign lsbf = ctrl[3];
  assign mstr = ctrl[4];
  assign en   = ctrl[5];
  assign ie   = ctrl[6];
  assign enh  = ctrl[7];

  always_comb
    case (ctrl[1:0])
      2'd0:    half = dbl ? DW'(1)  : DW'(2);
      2'd1:    half = dbl ? DW'(4)  : DW'(8);
      2'd2:    half = dbl ? DW'(16) : DW'(32);
      default: half = dbl ? DW'(32) : DW'(64);
    endcase

  assign busy    = run | (bcnt != '0);
  assign sel_s   = en & ~mstr & ~ss_s[1];
  assign tick    = run & (dcnt == half - DW'(1));
  assign rise    = mstr ? (tick & ~sck_q) : (sel_s & sck_s[1] & ~sck_s[2]);
  assign fall    = mstr ? (tick & sck_q)  : (sel_s & ~sck_s[1] & sck_s[2]);
  assign last    = fall & (bcnt == CW'(BITS - 1));
  assign out_bit = lsbf ? sh[0] : sh[BITS-1];
  assign nxt     = lsbf ? {lat, sh[BITS-1:1]} : {sh[BITS-2:0], lat};

  assign cwr    = bus_en & bus_we & (bus_addr == A_CTRL);
  assign srd    = bus_en & ~bus_we & (bus_addr == A_STAT);
  assign dwr    = bus_en & bus_we & (bus_addr == A_DATA);
  assign drd    = bus_en & ~bus_we & (bus_addr == A_DATA);
  assign load   = enh & en & txfull & ~busy;
  assign direct = ~enh & dwr & ~busy;
  assign wset   = dwr & (enh ? (txfull & ~load) : busy);
  assign clr    = armed & (dwr | drd);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; sh <= '0; rxbuf <= '0; txbuf <= '0;
      lat <= 1'b0; run <= 1'b0; sck_q <= 1'b0; spif <= 1'b0; wcol <= 1'b0;
      armed <= 1'b0; txfull <= 1'b0; bcnt <= '0; dcnt <= '0;
      sck_s <= '0; ss_s <= 2'b11; mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[0], ss_n};
      mosi_s <= {mosi_s[0], mosi_i};
      if (cwr) ctrl <= bus_wdata;
      dcnt <= (run & ~tick) ? dcnt + DW'(1) : '0;
      if (tick) sck_q <= ~sck_q;
      if (rise) lat <= mstr ? miso_i : mosi_s[1];
      if (fall) begin
        sh   <= nxt;
        bcnt <= bcnt + CW'(1);
      end else if (load) sh <= txbuf;
      else if (direct) sh <= bus_wdata;
      if (~mstr & ss_s[1]) bcnt <= '0;
      if (last) begin
        run   <= 1'b0;
        rxbuf <= nxt;
      end else if ((load | direct) & mstr & en) run <= 1'b1;
      if (enh & dwr & (~txfull | load)) begin
        txbuf  <= bus_wdata;
        txfull <= 1'b1;
      end else if (load) txfull <= 1'b0;
      spif <= last | (spif & ~clr);
      wcol <= wset | (wcol & ~clr);
      if (srd) armed <= 1'b1;
      else if (dwr | drd) armed <= 1'b0;
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {spif, wcol, 4'b0, busy, ~txfull};
      A_DATA:  bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase

  assign irq     = ie & spif;
  assign sck_o   = sck_q;
  assign sck_oe  = en & mstr;
  assign mosi_o  = out_bit;
  assign mosi_oe = en & mstr;
  assign miso_o  = out_bit;
  assign miso_oe = en & ~mstr & ~ss_n;

  p_slave_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mstr && ss_s[1]) |=> (bcnt == '0));
  p_sck_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sck_q));
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> spif);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(rxbuf));
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && busy && !enh && !fall) |=> (wcol && $stable(sh)));
  p_buf_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enh && dwr && txfull && !load) |=> (txfull && wcol && $stable(txbuf)));
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && last) |=> spif);
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n = 1'b1;

  int checks = 0, errs = 0, cyc = 0, per = 0;
  real lastr = 0.0;
  logic [31:0] hist = '0;
  logic [4:0] fcnt = '0, fbase = '0, idx;
  logic [15:0] in_pat = '0;

  spi_port dut (.*);

  always #2.5 clk = ~clk;

  assign idx = fcnt - fbase;
  assign miso_i = idx[4] ? 1'b0 : in_pat[4'd15 - idx[3:0]];

  always @(posedge sck_o) begin
    per = int'(($realtime - lastr) / 5.0);
    lastr = $realtime;
    hist = {hist[30:0], mosi_o};
  end
  always @(negedge sck_o) fcnt = fcnt + 5'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog R1..: cycles act=%0d exp<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errs + 1);
      $finish;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction
  function automatic logic [7:0] ser(input logic [7:0] b, input logic bl);
    return bl ? rev8(b) : b;
  endfunction
  function automatic int half_of(input logic [1:0] rt, input logic dbl);
    int h;
    case (rt)
      2'd0: h = 2; 2'd1: h = 8; 2'd2: h = 32; default: h = 64;
    endcase
    return dbl ? h / 2 : h;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask
  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask
  task automatic flush();
    logic [7:0] d;
    bus_rd(2'd1, d); bus_rd(2'd2, d);
  endtask

  task automatic xfer_m(input logic [7:0] t, input logic [7:0] s, input logic bl,
                        input logic dbl, input logic [1:0] rt);
    int h, k;
    logic [7:0] st, d;
    h = half_of(rt, dbl);
    bus_wr(2'd0, {1'b0, 1'b1, 1'b1, 1'b1, bl, dbl, rt});
    flush();
    in_pat = {ser(s, bl), 8'h00};
    fbase = fcnt;
    bus_wr(2'd2, t);
    k = 0;
    while (!irq && k < 5000) begin
      @(negedge clk); k++;
      ss_n = 1'($urandom);
    end
    chk(k == 16 * h, "R7 done timing", k, 16 * h);
    chk(per == 2 * h, "R4 sck period", per, 2 * h);
    chk((bl ? rev8(hist[7:0]) : hist[7:0]) == t, "R5 mosi order", hist[7:0], ser(t, bl));
    chk(sck_oe && mosi_oe && !miso_oe, "R1 master dirs", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    bus_rd(2'd1, st);
    chk(st[7] == 1'b1, "R7 flag", st, 8'h80);
    bus_rd(2'd2, d);
    chk(d == s, "R6 rx R2", d, s);
    bus_rd(2'd1, st);
    chk(st[7:6] == 2'b00, "R11 cleared", st[7:6], 0);
  endtask

  task automatic slave_bits(input logic [7:0] m, input logic bl, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      mosi_i = bl ? m[i] : m[7-i];
      repeat (8) @(negedge clk);
      got[bl ? i : 7 - i] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
  endtask

  task automatic xfer_s(input logic [7:0] t, input logic [7:0] m, input logic bl, input int pre);
    logic [7:0] st, d, got;
    bus_wr(2'd0, {1'b0, 1'b1, 1'b1, 1'b0, bl, 3'b000});
    ss_n = 1'b1; sck_i = 1'b0;
    flush();
    bus_wr(2'd2, t);
    repeat (4) @(negedge clk);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R1 slave deselected", {sck_oe, mosi_oe, miso_oe}, 0);
    repeat (3) begin
      sck_i = 1'b1; repeat (6) @(negedge clk);
      sck_i = 1'b0; repeat (6) @(negedge clk);
    end
    bus_rd(2'd1, st);
    chk(st[7] == 1'b0, "R3 no flag while ss high", st, 0);
    if (pre > 0) begin
      ss_n = 1'b0; repeat (8) @(negedge clk);
      slave_bits(8'h5A, bl, pre, got);
      repeat (8) @(negedge clk);
      ss_n = 1'b1; repeat (8) @(negedge clk);
      bus_wr(2'd2, t);
    end
    ss_n = 1'b0; repeat (8) @(negedge clk);
    chk(miso_oe && !sck_oe && !mosi_oe, "R1 slave selected", {sck_oe, mosi_oe, miso_oe}, 1);
    slave_bits(m, bl, 8, got);
    repeat (8) @(negedge clk);
    bus_rd(2'd1, st);
    chk(st[7] == 1'b1, "R7 slave flag R3", st, 8'h80);
    bus_rd(2'd2, d);
    chk(d == m, "R6 slave rx", d, m);
    chk(got == t, "R5 slave tx order", got, t);
    ss_n = 1'b1;
  endtask

  initial begin
    logic [7:0] st, d;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(2'd0, d);
    chk(d == 8'h00, "R12 ctrl reset", d, 0);
    bus_rd(2'd1, st);
    chk(st == 8'h01, "R12 status reset", st, 8'h01);
    chk(!irq && !sck_oe && !mosi_oe && !miso_oe, "R1 reset dirs", {irq, sck_oe, mosi_oe, miso_oe}, 0);
    bus_wr(2'd0, 8'hA5);
    bus_rd(2'd0, d);
    chk(d == 8'hA5, "R12 ctrl readback", d, 8'hA5);

    for (int r = 0; r < 4; r++) xfer_m(8'h3C ^ 8'(r), 8'hC1 + 8'(r), r[0], 1'b0, 2'(r));
    for (int r = 0; r < 4; r++) xfer_m(8'h96, 8'h1E, 1'b1, 1'b1, 2'(r));
    for (int r = 0; r < 10; r++)
      xfer_m(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom_range(0, 2)));

    // R9 normal-mode collision
    bus_wr(2'd0, 8'b0111_0101);
    flush();
    bus_wr(2'd2, 8'hA7);
    repeat (10) @(negedge clk);
    bus_wr(2'd2, 8'h42);
    bus_rd(2'd1, st);
    chk(st[7:6] == 2'b01 && st[1], "R9 wcol set busy", st, 8'h42);
    while (!irq) @(negedge clk);
    chk(hist[7:0] == 8'hA7, "R9 discarded write", hist[7:0], 8'hA7);
    bus_rd(2'd2, d);
    bus_rd(2'd1, st);
    chk(st[7:6] == 2'b00, "R11 both cleared", st, 0);

    // R10 enhanced buffer, R8 receive buffer
    bus_wr(2'd0, 8'b1111_0100);
    flush();
    in_pat = {8'h6D, 8'hB2};
    fbase = fcnt;
    bus_wr(2'd2, 8'h81);
    bus_wr(2'd2, 8'h7E);
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd1, st);
    chk(st[6] && !st[0] && st[1], "R10 full and wcol", st, 8'h42);
    repeat (20) @(negedge clk);
    bus_rd(2'd2, d);
    chk(d == 8'h6D, "R8 first byte held", d, 8'h6D);
    repeat (20) @(negedge clk);
    bus_rd(2'd1, st);
    chk(st[7] && st[0] && !st[1], "R10 drained", st, 8'h81);
    bus_rd(2'd2, d);
    chk(d == 8'hB2, "R8 second byte", d, 8'hB2);
    chk(hist[15:0] == 16'h817E, "R10 back-to-back", hist[15:0], 16'h817E);

    // slave mode
    xfer_s(8'hC3, 8'h5B, 1'b0, 0);
    xfer_s(8'h1D, 8'hE4, 1'b1, 3);
    xfer_s(8'h70, 8'h0F, 1'b0, 5);

    // R11 completion vs clearing access in the same cycle
    for (int k = 13; k <= 19; k++) begin
      bus_wr(2'd0, 8'b0011_0100);
      flush();
      bus_wr(2'd2, 8'($urandom));
      bus_rd(2'd1, st);
      repeat (k - 2) @(negedge clk);
      bus_rd(2'd2, d);
      repeat (24 - k) @(negedge clk);
      bus_rd(2'd1, st);
      chk(st[7] == (k <= 16), "R11 set wins", st[7], (k <= 16));
      chk(!irq, "R7 irq masked", irq, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule